// File: doc/BRIEF.md
# Bidirectional Parallel Flash Boot Reader

This block fetches a boot image from a byte-wide parallel NOR flash after power-up or after a program request. When its init-release input rises, it samples a three-bit strap. If the strap selects parallel-flash boot, the block drives the flash chip enable and output enable low and sweeps the address bus. The sweep either counts up from address zero or counts down from the top of the address space. This lets the flash share its lower or upper region with another boot master that starts from the opposite end.

Each read waits a fixed access latency after the address settles and then captures the data byte. The byte is offered on a valid/ready stream and held until the consumer takes it. Only then does the address step to the next location. After a parameterized number of bytes, the block deselects the flash, stops driving the address and raises a done flag. Pulling the active-low program input low abandons whatever is in progress, so another master can use the flash.

Top module: `flash_boot_reader`

## Requirements
- R1: The strap `modeStrap` is sampled only in the cycle where a rising edge of `initRel` is seen (`initRel` high, low the cycle before). Changes to the strap at any other time do not alter the mode or the sweep direction.
- R2: The block starts a read only when the sampled strap has bit 2 = 0 and bit 1 = 1. For any other strap value it stays idle: `flashCeN` and `flashOeN` are high, `flashAddrOe` is low and `outValid` is low.
- R3: With strap bit 0 = 0, the first address is 0x000000 and each later read uses the previous address plus one.
- R4: With strap bit 0 = 1, the first address is 0xFFFFFF and each later read uses the previous address minus one.
- R5: From the start of the sweep until the last byte is accepted, `flashCeN` and `flashOeN` are low and `flashAddrOe` is high. Each offered byte equals the flash data at the address then on `flashAddr`.
- R6: After the sweep starts, and after every accepted byte that is not the last, `outValid` stays low for exactly ACCESS_LAT cycles before the next byte is offered.
- R7: While `outValid` is high and `outReady` is low, `outValid`, `outData` and `flashAddr` hold their values.
- R8: `bootDone` rises in the cycle after the last of BYTE_COUNT bytes is accepted and stays high until `progN` goes low. While it is high, `flashCeN` is high, `flashAddrOe` is low and `outReady` has no effect.
- R9: A low on `progN` at a clock edge returns the block to idle in the next cycle: `flashCeN` and `flashOeN` high, `outValid`, `bootDone` and `sweepErr` low. A new sweep then needs a new rising edge of `initRel`.
- R10: The address never wraps. If a byte is accepted at the last address of the space in the sweep direction (all ones going up, zero going down) and more bytes remain, the block raises `sweepErr`, deselects the flash, releases the address and does not raise `bootDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progN | input | 1 | Active-low program request; aborts and restarts |
| initRel | input | 1 | Init release; its rising edge samples the strap |
| modeStrap | input | 3 | Boot mode strap |
| flashAddr | output | ADDR_W | Flash address |
| flashAddrOe | output | 1 | High while the address bus is driven |
| flashCeN | output | 1 | Flash chip enable, active low |
| flashOeN | output | 1 | Flash output enable, active low |
| flashData | input | DATA_W | Flash data |
| outData | output | DATA_W | Captured byte |
| outValid | output | 1 | Byte available |
| outReady | input | 1 | Consumer takes the byte |
| bootDone | output | 1 | All bytes delivered |
| sweepErr | output | 1 | Sweep ran into the end of the address space |

## Verification
The assertions assume that `flashData` is a function of the current address, that `progN` is held high for a whole sweep except when an abort is intended, and that the strap direction cannot change while a byte is held. The bench models the flash as a combinational function of the address and drives `progN`, `initRel` and `modeStrap` only on falling clock edges. It changes the strap to a conflicting value right after it has been sampled. Every strap value is tried, and the consumer stalls for zero cycles, a varying number of cycles or a fixed number of cycles. A second instance with a 4-bit address space and more bytes than it can hold drives both sweep directions into the end of the space.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HOLD,
    ST_DONE,
    ST_ERR
  } rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic sampleMode;
    logic loadStart;
    logic latStep;
    logic capture;
    logic accept;
    logic advance;
  } fbrStrobe_t;

endpackage

// File: rtl/fbr_ctrl.sv
module fbr_ctrl
  import fbr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       progN,
  input  logic       initRel,
  input  logic [2:0] modeStrap,
  input  logic       outReady,
  input  logic       latDone,
  input  logic       lastByte,
  input  logic       atEnd,
  output fbrStrobe_t stb,
  output logic       busRead,
  output logic       holdByte,
  output logic       finished,
  output logic       fault
);

  rdState_t state, nxt;
  logic initPrev;
  logic initRise;
  logic isFlash;

  assign initRise = initRel & ~initPrev;
  assign isFlash  = ~modeStrap[2] & modeStrap[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      initPrev <= 1'b0;
    end else begin
      state    <= nxt;
      initPrev <= initRel;
    end
  end

  always_comb begin
    nxt = state;
    stb = '0;
    unique case (state)
      ST_IDLE: begin
        if (initRise && isFlash) begin
          stb.sampleMode = 1'b1;
          stb.loadStart  = 1'b1;
          nxt            = ST_WAIT;
        end
      end
      ST_WAIT: begin
        stb.latStep = 1'b1;
        if (latDone) begin
          stb.capture = 1'b1;
          nxt         = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (outReady) begin
          stb.accept = 1'b1;
          if (lastByte) begin
            nxt = ST_DONE;
          end else if (atEnd) begin
            nxt = ST_ERR;
          end else begin
            stb.advance = 1'b1;
            nxt         = ST_WAIT;
          end
        end
      end
      ST_DONE: nxt = ST_DONE;
      ST_ERR:  nxt = ST_ERR;
      default: nxt = ST_IDLE;
    endcase
    if (!progN) begin
      nxt = ST_IDLE;
      stb = '0;
    end
  end

  assign busRead  = (state == ST_WAIT) || (state == ST_HOLD);
  assign holdByte = (state == ST_HOLD);
  assign finished = (state == ST_DONE);
  assign fault    = (state == ST_ERR);

endmodule

// File: rtl/fbr_datapath.sv
module fbr_datapath
  import fbr_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 8,
  parameter int ACCESS_LAT = 2,
  parameter int BYTE_COUNT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fbrStrobe_t        stb,
  input  logic              modeDir,
  input  logic [DATA_W-1:0] flashData,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dataOut,
  output logic              dirDown,
  output logic              latDone,
  output logic              lastByte,
  output logic              atEnd
);

  localparam int LAT_W = $clog2(ACCESS_LAT + 1);
  localparam int CNT_W = $clog2(BYTE_COUNT + 1);
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(ACCESS_LAT - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_COUNT - 1);

  logic [LAT_W-1:0] latCnt;
  logic [CNT_W-1:0] byteCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirDown <= 1'b0;
      addr    <= '0;
    end else begin
      if (stb.sampleMode) dirDown <= modeDir;
      if (stb.loadStart) begin
        addr <= modeDir ? '1 : '0;
      end else if (stb.advance) begin
        addr <= dirDown ? addr - 1'b1 : addr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latCnt <= '0;
    end else if (stb.loadStart || stb.capture) begin
      latCnt <= '0;
    end else if (stb.latStep) begin
      latCnt <= latCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
    end else if (stb.loadStart) begin
      byteCnt <= '0;
    end else if (stb.accept) begin
      byteCnt <= byteCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
    end else if (stb.capture) begin
      dataOut <= flashData;
    end
  end

  assign latDone  = (latCnt == LAT_LAST);
  assign lastByte = (byteCnt == CNT_LAST);
  assign atEnd    = dirDown ? (addr == '0) : (addr == '1);

endmodule

// File: rtl/flash_boot_reader.sv
module flash_boot_reader
  import fbr_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 8,
  parameter int ACCESS_LAT = 2,
  parameter int BYTE_COUNT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progN,
  input  logic              initRel,
  input  logic [2:0]        modeStrap,
  output logic [ADDR_W-1:0] flashAddr,
  output logic              flashAddrOe,
  output logic              flashCeN,
  output logic              flashOeN,
  input  logic [DATA_W-1:0] flashData,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              bootDone,
  output logic              sweepErr
);

  fbrStrobe_t stb;
  logic latDone, lastByte, atEnd, dirDown, busRead;

  fbr_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .progN    (progN),
    .initRel  (initRel),
    .modeStrap(modeStrap),
    .outReady (outReady),
    .latDone  (latDone),
    .lastByte (lastByte),
    .atEnd    (atEnd),
    .stb      (stb),
    .busRead  (busRead),
    .holdByte (outValid),
    .finished (bootDone),
    .fault    (sweepErr)
  );

  fbr_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ACCESS_LAT(ACCESS_LAT),
    .BYTE_COUNT(BYTE_COUNT)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .modeDir  (modeStrap[0]),
    .flashData(flashData),
    .addr     (flashAddr),
    .dataOut  (outData),
    .dirDown  (dirDown),
    .latDone  (latDone),
    .lastByte (lastByte),
    .atEnd    (atEnd)
  );

  assign flashCeN    = ~busRead;
  assign flashOeN    = ~busRead;
  assign flashAddrOe = busRead;

endmodule

// File: rtl/fbr_checker.sv
module fbr_checker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              progN,
  input logic [ADDR_W-1:0] flashAddr,
  input logic              flashAddrOe,
  input logic              flashCeN,
  input logic              flashOeN,
  input logic [DATA_W-1:0] outData,
  input logic              outValid,
  input logic              outReady,
  input logic              bootDone,
  input logic              sweepErr,
  input logic              dirDown
);

  a_r5_enables_with_byte: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (!flashCeN && !flashOeN && flashAddrOe));

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rstN || !progN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(flashAddr)));

  a_r3_ascend_step: assert property (@(posedge clk) disable iff (!rstN || !progN)
    (outValid && outReady && !dirDown) |=>
      (!flashAddrOe || flashAddr == $past(flashAddr) + 1'b1));

  a_r4_descend_step: assert property (@(posedge clk) disable iff (!rstN || !progN)
    (outValid && outReady && dirDown) |=>
      (!flashAddrOe || flashAddr == $past(flashAddr) - 1'b1));

  a_r8_done_released: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |-> (flashCeN && !flashAddrOe && !outValid));

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (bootDone && progN) |=> bootDone);

  a_r9_abort: assert property (@(posedge clk) disable iff (!rstN)
    !progN |=> (flashCeN && flashOeN && !outValid && !bootDone && !sweepErr));

  a_r10_err_released: assert property (@(posedge clk) disable iff (!rstN)
    sweepErr |-> (!bootDone && flashCeN && !flashAddrOe));

endmodule

bind flash_boot_reader fbr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (.*);

// File: tb/flash_boot_reader_test.sv
module flash_boot_reader_test;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 2;
  localparam int NBYTES     = 5;
  localparam int SMALL_W    = 4;
  localparam int SMALL_N    = 20;

  logic clk = 1'b0;
  logic rstN, progN, initRel, outReady;
  logic [2:0] modeStrap;

  logic [23:0] addrA;
  logic oeA, ceA, oeNA, validA, doneA, errA;
  logic [7:0] dataA, outA;

  logic [SMALL_W-1:0] addrB;
  logic oeB, ceB, oeNB, validB, doneB, errB;
  logic [7:0] dataB, outB;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] fdata(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  assign dataA = fdata(addrA);
  assign dataB = fdata({20'h0, addrB});

  flash_boot_reader #(.ADDR_W(24), .DATA_W(8), .ACCESS_LAT(LAT), .BYTE_COUNT(NBYTES)) uut (
    .clk(clk), .rstN(rstN), .progN(progN), .initRel(initRel), .modeStrap(modeStrap),
    .flashAddr(addrA), .flashAddrOe(oeA), .flashCeN(ceA), .flashOeN(oeNA),
    .flashData(dataA), .outData(outA), .outValid(validA), .outReady(outReady),
    .bootDone(doneA), .sweepErr(errA));

  flash_boot_reader #(.ADDR_W(SMALL_W), .DATA_W(8), .ACCESS_LAT(LAT), .BYTE_COUNT(SMALL_N)) uutSmall (
    .clk(clk), .rstN(rstN), .progN(progN), .initRel(initRel), .modeStrap(modeStrap),
    .flashAddr(addrB), .flashAddrOe(oeB), .flashCeN(ceB), .flashOeN(oeNB),
    .flashData(dataB), .outData(outB), .outValid(validB), .outReady(outReady),
    .bootDone(doneB), .sweepErr(errB));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // program pulse, strap, init rise; strap is then scrambled (R1)
  task automatic startBoot(input logic [2:0] m);
    @(negedge clk);
    progN = 1'b0; initRel = 1'b0; outReady = 1'b0; modeStrap = m;
    @(negedge clk);
    progN = 1'b1;
    @(negedge clk);
    initRel = 1'b1;
    @(negedge clk);
    modeStrap = {1'b1, 1'b0, ~m[0]};
  endtask

  task automatic readAll(input bit down, input int pat);
    logic [23:0] expAddr = down ? 24'hFFFFFF : 24'h0;
    for (int i = 0; i < NBYTES; i++) begin
      int gap = 0;
      int stall;
      while (!validA && gap < 50) begin
        gap++;
        @(negedge clk);
      end
      chk("R6 latency gap", gap, LAT);
      chk(down ? "R1 R4 address" : "R1 R3 address", addrA, expAddr);
      chk("R5 byte matches flash", outA, fdata(expAddr));
      chk("R5 enables", {ceA, oeNA, oeA}, 3'b001);
      stall = (pat == 0) ? 0 : (pat == 1) ? (i % 3) : 4;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk("R7 held", {validA, addrA, outA}, {1'b1, expAddr, fdata(expAddr)});
      end
      outReady = 1'b1;
      @(negedge clk);
      outReady = 1'b0;
      if (i == NBYTES - 1) begin
        chk("R8 done after last", {doneA, ceA, oeA, validA}, 4'b1100);
      end else begin
        expAddr = down ? expAddr - 1'b1 : expAddr + 1'b1;
      end
    end
    for (int k = 0; k < 4; k++) begin
      outReady = k[0];
      @(negedge clk);
      chk("R8 done sticky", {doneA, ceA, oeA}, 3'b110);
    end
    outReady = 1'b0;
  endtask

  task automatic sweepSmall(input bit down);
    int cnt = 0;
    int expB = down ? 15 : 0;
    startBoot(down ? 3'b011 : 3'b010);
    outReady = 1'b1;
    repeat (200) begin
      @(negedge clk);
      if (validB) begin
        chk("R10 small address", addrB, expB[3:0]);
        cnt++;
        expB = down ? expB - 1 : expB + 1;
      end
    end
    outReady = 1'b0;
    chk("R10 bytes before stop", cnt, 16);
    chk("R10 error released", {errB, doneB, ceB, oeB}, 4'b1010);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; progN = 1'b1; initRel = 1'b0; outReady = 1'b0; modeStrap = 3'b000;
    repeat (3) @(negedge clk);
    chk("R2 reset idle", {ceA, oeNA, oeA, validA, doneA, errA}, 6'b110000);
    rstN = 1'b1;

    // every strap value that does not select flash boot
    for (int m = 0; m < 8; m++) begin
      if (m[2:1] != 2'b01) begin
        startBoot(3'(m));
        repeat (6) @(negedge clk);
        chk("R2 non-flash strap idle", {ceA, oeNA, oeA, validA, doneA}, 5'b11000);
      end
    end

    startBoot(3'b010); readAll(1'b0, 0);
    startBoot(3'b011); readAll(1'b1, 1);
    startBoot(3'b010); readAll(1'b0, 2);
    startBoot(3'b011); readAll(1'b1, 0);

    // abort in the middle of a sweep
    startBoot(3'b010);
    while (!validA) @(negedge clk);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    while (!validA) @(negedge clk);
    progN = 1'b0;
    @(negedge clk);
    progN = 1'b1;
    chk("R9 abort releases", {ceA, oeNA, validA, doneA, errA}, 5'b11000);
    repeat (8) @(negedge clk);
    chk("R9 no restart without init rise", {ceA, validA}, 2'b10);
    startBoot(3'b010); readAll(1'b0, 1);

    sweepSmall(1'b0);
    sweepSmall(1'b1);

    // abort clears the error state
    progN = 1'b0;
    @(negedge clk);
    progN = 1'b1;
    chk("R9 abort clears error", {errB, doneB, ceB}, 3'b001);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule